// File: doc/BRIEF.md
# Smart-Card Contact Clock Divider

This block derives the clock presented to a smart card's contact pin from the chip's master clock. It has two stages. A programmable prescaler counts master clock cycles and, once every N+1 cycles, emits a single-cycle enable tick. That tick feeds the downstream elementary-time-unit counter, which lies outside this block. A toggle flip-flop then flips on each tick, so the card clock runs at the master rate divided by 2(N+1) with an even duty cycle.

The ratio N comes from a 6-bit field that sits in the low bits of an 8-bit configuration register. Software may rewrite the register at any moment. The prescaler takes the new ratio only when its count wraps. The count in progress therefore always finishes at the ratio it started with, and the card clock can never show a short pulse. A stored value of zero divides as if it were one.

Top module: `sc_clkdiv`

## Requirements
- R1: While reset is asserted, card_clk is low, etu_tick is low and rd_data reads 0x0C. After reset is released, the first etu_tick is visible 13 master cycles later.
- R2: After a write, rd_data returns the low 6 bits of wr_data in bits 5:0. A stored zero reads back as 0x00.
- R3: For a stored value N from 1 to 63, consecutive etu_tick pulses are exactly N+1 master cycles apart.
- R4: card_clk comes from a flip-flop. It changes state in the master cycle right after each etu_tick pulse and in no other cycle, so its high time and its low time are each N+1 master cycles.
- R5: A stored value of 0 gives the same division as 1: ticks 2 cycles apart and card_clk pulse widths of 2 cycles.
- R6: A write that lands in the middle of a count leaves that period unchanged, at the old ratio. The new ratio applies from the next period.
- R7: etu_tick is high for exactly one master cycle each time it pulses.
- R8: Bits 7:6 of wr_data are ignored. They always read back as zero and have no effect on the division (0xCC divides like 0x0C).
- R9: Under any sequence of writes, every high or low pulse on card_clk lasts either the old or the new effective ratio in master cycles, and no other length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Register write value; bits 5:0 hold the divide field |
| rd_data | output | 8 | Register readback, upper two bits zero |
| etu_tick | output | 1 | One-cycle enable for the ETU divider, once per prescaler period |
| card_clk | output | 1 | Card contact clock with 50% duty cycle |

## Verification
If the terminal count is wrong, the tick spacing is wrong within one prescaler period, so the fault shows on the very next tick gap. If the count is reloaded at the wrong moment, one pulse on card_clk has a width that matches neither the old ratio nor the new one. This shows in the period that straddles the write, which is why pulse widths are measured right after each write. A defect in the toggle stage shows as a card_clk edge that is not one cycle after a tick, or as a level that is wrong during reset. A defect in the register shows on rd_data one cycle after the write.

// File: rtl/sc_clkdiv_pkg.sv
package sc_clkdiv_pkg;
   localparam int unsigned SCD_FIELD_W = 6;
   localparam int unsigned SCD_REG_W   = 8;
   localparam int unsigned SCD_RESET   = 12;

   // A field value of zero divides like one.
   function automatic int unsigned scd_eff(input int unsigned v);
      return (v == 0) ? 1 : v;
   endfunction
endpackage

// File: rtl/sc_clkdiv_cfg.sv
module sc_clkdiv_cfg #(
   parameter int unsigned FIELD_W   = 6,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned RESET_VAL = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [FIELD_W-1:0] field,
   output logic [REG_W-1:0]   rd_data
);
   localparam int unsigned PAD_W = REG_W - FIELD_W;

   logic [FIELD_W-1:0] field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= FIELD_W'(RESET_VAL);
      else if (wr_en)
         field_q <= wr_data[FIELD_W-1:0];
   end

   assign field = field_q;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, field_q};
      end else begin : g_nopad
         assign rd_data = field_q;
      end
   endgenerate
endmodule

// File: rtl/sc_clkdiv_presc.sv
module sc_clkdiv_presc
   import sc_clkdiv_pkg::*;
#(
   parameter int unsigned FIELD_W   = 6,
   parameter int unsigned RESET_VAL = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] ratio_src,
   output logic               tick
);
   localparam logic [FIELD_W-1:0] TERM_RST = FIELD_W'(scd_eff(RESET_VAL));

   logic [FIELD_W-1:0] cnt_q;
   logic [FIELD_W-1:0] term_q;
   logic [FIELD_W-1:0] term_nxt;
   logic               wrap;

   assign term_nxt = (ratio_src == '0) ? FIELD_W'(1) : ratio_src;
   assign wrap     = (cnt_q == term_q);

   // The terminal count is taken only at the wrap, so no period is cut short.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         term_q <= TERM_RST;
         tick   <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         term_q <= term_nxt;
         tick   <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick   <= 1'b0;
      end
   end
endmodule

// File: rtl/sc_clkdiv_tgl.sv
module sc_clkdiv_tgl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic card_clk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         card_clk <= 1'b0;
      else if (tick)
         card_clk <= ~card_clk;
   end
endmodule

// File: rtl/sc_clkdiv.sv
module sc_clkdiv
   import sc_clkdiv_pkg::*;
#(
   parameter int unsigned FIELD_W   = SCD_FIELD_W,
   parameter int unsigned REG_W     = SCD_REG_W,
   parameter int unsigned RESET_VAL = SCD_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             etu_tick,
   output logic             card_clk
);
   generate
      if (FIELD_W < 1) begin : g_bad_field
         $error("sc_clkdiv: FIELD_W must be at least 1");
      end
      if (REG_W < FIELD_W) begin : g_bad_reg
         $error("sc_clkdiv: REG_W must not be narrower than FIELD_W");
      end
      if (RESET_VAL >= (1 << FIELD_W)) begin : g_bad_rst
         $error("sc_clkdiv: RESET_VAL does not fit the field");
      end
   endgenerate

   logic [FIELD_W-1:0] field;

   sc_clkdiv_cfg #(
      .FIELD_W  (FIELD_W),
      .REG_W    (REG_W),
      .RESET_VAL(RESET_VAL)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .field  (field),
      .rd_data(rd_data)
   );

   sc_clkdiv_presc #(
      .FIELD_W  (FIELD_W),
      .RESET_VAL(RESET_VAL)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio_src(field),
      .tick     (etu_tick)
   );

   sc_clkdiv_tgl u_tgl (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (etu_tick),
      .card_clk(card_clk)
   );
endmodule

// File: rtl/sc_clkdiv_chk.sv
module sc_clkdiv_chk #(
   parameter int unsigned FIELD_W = 6,
   parameter int unsigned REG_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             etu_tick,
   input logic             card_clk
);
   localparam int unsigned GAP_W   = FIELD_W + 2;
   localparam int unsigned GAP_MAX = 1 << FIELD_W;

   logic [GAP_W-1:0] gap;
   logic             seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (etu_tick) begin
         gap  <= GAP_W'(1);
         seen <= 1'b1;
      end else if (gap != {GAP_W{1'b1}}) begin
         gap  <= gap + 1'b1;
      end
   end

   a_r7_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      etu_tick |=> !etu_tick);

   a_r4_edge_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (card_clk != $past(card_clk)) |-> $past(etu_tick));

   a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[FIELD_W-1:0] == $past(wr_data[FIELD_W-1:0]));

   a_r3_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (etu_tick && seen) |-> (gap >= GAP_W'(2) && gap <= GAP_W'(GAP_MAX)));

   a_r1_clk_low_in_reset: assert property (@(posedge clk)
      !rst_n |-> !card_clk);

   generate
      if (REG_W > FIELD_W) begin : g_upper
         a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[REG_W-1:FIELD_W] == '0);
      end
   endgenerate
endmodule

bind sc_clkdiv sc_clkdiv_chk #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/sc_clkdiv_bench.sv
module sc_clkdiv_bench;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       etu_tick;
   logic       card_clk;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_clkdiv u_sc_clkdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .etu_tick(etu_tick),
      .card_clk(card_clk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff(input int v);
      return ((v & 63) == 0) ? 2 : (v & 63) + 1;
   endfunction

   task automatic do_write(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_tick();
      int g = 0;
      do begin @(negedge clk); g++; end while (!etu_tick && g < 300);
   endtask

   task automatic tick_gap(output int g);
      g = 0;
      do begin @(negedge clk); g++; end while (!etu_tick && g < 300);
   endtask

   task automatic clk_width(output int w);
      logic prev = card_clk;
      int g = 0;
      do begin @(negedge clk); g++; end while (card_clk == prev && g < 300);
      prev = card_clk;
      w = 0;
      do begin @(negedge clk); w++; end while (card_clk == prev && w < 300);
   endtask

   task automatic t_reset();
      int n;
      repeat (3) @(negedge clk);
      chk(card_clk == 1'b0, "R1 clk low in reset", card_clk, 0);
      chk(etu_tick == 1'b0, "R1 tick low in reset", etu_tick, 0);
      chk(rd_data == 8'h0C, "R1 reset value", rd_data, 12);
      rst_n = 1'b1;
      tick_gap(n);
      chk(n == 13, "R1 first tick delay", n, 13);
      tick_gap(n);
      chk(n == 13, "R3 default gap", n, 13);
   endtask

   task automatic t_readback();
      do_write(8'hFF);
      chk(rd_data == 8'h3F, "R8 upper bits read zero", rd_data, 63);
      do_write(8'h00);
      chk(rd_data == 8'h00, "R2 zero reads back zero", rd_data, 0);
      do_write(8'h15);
      chk(rd_data == 8'h15, "R2 readback", rd_data, 21);
   endtask

   task automatic t_zero();
      int g;
      do_write(8'h00);
      wait_tick();
      tick_gap(g);
      chk(g == 2, "R5 zero tick gap", g, 2);
      clk_width(g);
      chk(g == 2, "R5 zero clk width", g, 2);
   endtask

   task automatic t_ratio(input int n);
      int g;
      logic c0;
      do_write(8'(n));
      wait_tick();
      wait_tick();
      c0 = card_clk;
      @(negedge clk);
      chk(!etu_tick, "R7 tick one cycle", etu_tick, 0);
      chk(card_clk != c0, "R4 edge after tick", card_clk, int'(!c0));
      wait_tick();
      tick_gap(g);
      chk(g == n + 1, "R3 tick gap", g, n + 1);
      clk_width(g);
      chk(g == n + 1, "R4 clk width", g, n + 1);
   endtask

   task automatic t_upper();
      int g;
      do_write(8'hCC);
      chk(rd_data == 8'h0C, "R8 upper bits ignored readback", rd_data, 12);
      wait_tick();
      tick_gap(g);
      chk(g == 13, "R8 upper bits no effect", g, 13);
   endtask

   task automatic t_midcount();
      int g;
      do_write(8'd20);
      wait_tick();
      wait_tick();
      g = 0;
      do begin
         @(negedge clk);
         g++;
         if (g == 3) begin wr_en = 1'b1; wr_data = 8'd5; end
         if (g == 4) wr_en = 1'b0;
      end while (!etu_tick && g < 300);
      chk(g == 21, "R6 current period keeps old ratio", g, 21);
      tick_gap(g);
      chk(g == 6, "R6 next period uses new ratio", g, 6);
   endtask

   task automatic t_random();
      int oldr = 6;
      int newr;
      int w;
      for (int i = 0; i < 8; i++) begin
         logic [7:0] v = 8'($urandom);
         newr = eff(int'(v));
         do_write(v);
         for (int k = 0; k < 4; k++) begin
            clk_width(w);
            chk(w == oldr || w == newr, "R9 width old or new", w, newr);
         end
         chk(w == newr, "R9 settles to new", w, newr);
         oldr = newr;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_readback();
      t_zero();
      t_ratio(1);
      t_ratio(7);
      t_ratio(40);
      t_ratio(63);
      t_upper();
      t_midcount();
      t_random();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule